// File: doc/BRIEF.md
# Frame Sequence Restart Controller

This block keeps two frame-sequence counters for a video timing path. The first counts a ten-frame identification cycle and emits a one-clock marker whenever its count returns to zero. The second is an auxiliary sequence counter of configurable length that emits the same kind of marker. Both counters advance only on the frame-start strobe. The surrounding timing generator supplies this strobe once per frame.

Either counter can be restarted in two ways. The first is a reference-derived strobe, which takes effect at the frame boundary where it appears. The second is a software request issued through a control word. Software arms the request by taking a trigger bit high and then low again. The request is held pending and only takes effect at the next frame boundary. Two enable bits in the same word select which counters that deferred restart reaches.

The ten-frame counter stays idle after reset. It does not begin counting until one of the two restart sources starts it. The auxiliary counter runs from reset.

Top module: `frame_seq_restart`

## Requirements
- R1: After reset, both counts are 0, both markers are low, the ten-frame counter is idle and no software restart is pending.
- R2: Once started, the ten-frame count advances by one on each clock where frame_start is high, and wraps from 9 to 0. In the clock after each frame_start whose new count is 0, tid_pulse is high for exactly one clock.
- R3: The auxiliary count runs from reset through 0 to AUX_LEN-1 and wraps on frame_start. In the clock after each frame_start whose new count is 0, aux_pulse is high for one clock.
- R4: Without a restart, the ten-frame counter stays idle, with count 0 and no marker, whatever number of frames passes.
- R5: A software restart is armed only by a high-to-low transition of ctrl_word bit 0. A rising edge or a steady high level arms nothing.
- R6: An armed restart has no effect until the next frame_start. At that boundary the selected counters are set to 0 and their markers fire.
- R7: ctrl_word bit 1 lets the deferred restart reach the ten-frame counter, and bit 2 lets it reach the auxiliary counter. Both bits are read at the boundary where the restart is applied. A counter whose bit is clear keeps counting normally.
- R8: A pending restart is cleared once applied, so one arming gives exactly one restart.
- R9: ref_sync high together with frame_start restarts both counters to 0, independent of the enable bits and of any pending request.
- R10: When ref_sync and a pending software restart fall on the same boundary, each counter is restarted once to 0. The next frame then continues from 1.
- R11: ctrl_word bits above bit 2 have no effect on arming or on either counter.
- R12: A trigger falling edge in the same clock as frame_start counts as belonging to the new frame. The restart it arms is applied at the following frame_start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-clock strobe marking a frame boundary |
| ref_sync | input | 1 | Reference-derived restart, honoured with frame_start |
| ctrl_word | input | CTRL_W | Bit 0 trigger, bit 1 ten-frame enable, bit 2 auxiliary enable |
| tid_pulse | output | 1 | Ten-frame identification marker |
| tid_count | output | TID_W | Ten-frame sequence count |
| aux_pulse | output | 1 | Auxiliary sequence marker |
| aux_count | output | AUX_W | Auxiliary sequence count |

## Verification
The two functions that can fall in the same cycle are the reference restart and the application of a pending software restart, which meet at one frame boundary. The bench arms a request for both counters in one frame. It then drives ref_sync with the next frame_start and expects both counts at 0 with both markers high. The frame after that must read 1, which shows that no second restart was applied. A trigger falling edge is also made to coincide with frame_start, and that request is judged by when it lands: one frame later.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

    // Control word field positions (decoded by frame_seq_restart)
    localparam int unsigned CTL_TRIG   = 0;
    localparam int unsigned CTL_TID_EN = 1;
    localparam int unsigned CTL_AUX_EN = 2;
    localparam int unsigned CTL_USED   = 3;

    typedef struct packed {
        logic trig_prev;
        logic pending;
    } arm_state_t;

endpackage

// File: rtl/seq_reset_arm.sv
module seq_reset_arm
    import frame_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic trig,
    output logic pending,
    output logic fire
);

    arm_state_t st_d, st_q;
    logic       arm_evt;

    always_comb begin
        st_d           = st_q;
        arm_evt        = st_q.trig_prev & ~trig;
        st_d.trig_prev = trig;
        if (frame_start) begin
            // pending request is consumed here; a new edge now belongs to the new frame
            st_d.pending = arm_evt;
        end else begin
            st_d.pending = st_q.pending | arm_evt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending = st_q.pending;
    assign fire    = frame_start & st_q.pending;

    AST_ARM_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.trig_prev && !trig) |=> pending); // R5

    AST_PENDING_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start && pending) |=> pending); // R6

    AST_FIRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !(st_q.trig_prev && !trig)) |=> !pending); // R8

endmodule

// File: rtl/seq_counter.sv
module seq_counter #(
    parameter int unsigned LEN       = 10,
    parameter int unsigned CW        = 4,
    parameter bit          START_RUN = 1'b0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          restart,
    output logic [CW-1:0] count,
    output logic          pulse,
    output logic          running
);

    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
        logic          pls;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.pls = 1'b0;
        if (frame_start) begin
            if (restart) begin
                st_d.run = 1'b1;
                st_d.cnt = '0;
            end else if (st_q.run) begin
                st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
            end
            st_d.pls = st_d.run && (st_d.cnt == '0);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.run <= START_RUN;
            st_q.cnt <= '0;
            st_q.pls <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count   = st_q.cnt;
    assign pulse   = st_q.pls;
    assign running = st_q.run;

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        count <= LAST); // R2

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && restart) |=> (count == '0) && pulse && running); // R6

    AST_WRAP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !restart && running && count == LAST) |=> (count == '0) && pulse); // R3

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(count) && !pulse); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (count == '0) && !pulse); // R4

endmodule

// File: rtl/frame_seq_restart.sv
module frame_seq_restart
    import frame_seq_pkg::*;
#(
    parameter int unsigned CTRL_W  = 8,
    parameter int unsigned TID_LEN = 10,
    parameter int unsigned AUX_LEN = 5,
    parameter int unsigned TID_W   = $clog2(TID_LEN),
    parameter int unsigned AUX_W   = $clog2(AUX_LEN)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              ref_sync,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic              tid_pulse,
    output logic [TID_W-1:0]  tid_count,
    output logic              aux_pulse,
    output logic [AUX_W-1:0]  aux_count
);

    logic sw_pending;
    logic sw_fire;
    logic tid_restart;
    logic aux_restart;
    logic tid_running;
    logic aux_running;

    generate
        if (CTRL_W > CTL_USED) begin : g_spare
            logic unused_spare;
            assign unused_spare = ^ctrl_word[CTRL_W-1:CTL_USED];
        end
    endgenerate

    seq_reset_arm u_arm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .trig       (ctrl_word[CTL_TRIG]),
        .pending    (sw_pending),
        .fire       (sw_fire)
    );

    // either source restarts; a coincidence merges into a single restart
    assign tid_restart = ref_sync | (sw_fire & ctrl_word[CTL_TID_EN]);
    assign aux_restart = ref_sync | (sw_fire & ctrl_word[CTL_AUX_EN]);

    seq_counter #(
        .LEN      (TID_LEN),
        .CW       (TID_W),
        .START_RUN(1'b0)
    ) u_tid (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .restart    (tid_restart),
        .count      (tid_count),
        .pulse      (tid_pulse),
        .running    (tid_running)
    );

    seq_counter #(
        .LEN      (AUX_LEN),
        .CW       (AUX_W),
        .START_RUN(1'b1)
    ) u_aux (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .restart    (aux_restart),
        .count      (aux_count),
        .pulse      (aux_pulse),
        .running    (aux_running)
    );

    AST_REF_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && ref_sync) |=> (tid_count == '0) && (aux_count == '0) && tid_pulse && aux_pulse); // R9

    AST_SW_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && !ref_sync && sw_pending && !ctrl_word[CTL_TID_EN] && !tid_running) |=> !tid_pulse); // R7

    AST_AUX_ALWAYS_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        aux_running); // R3

    AST_NO_EARLY_SW: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_start) |=> !tid_pulse && !aux_pulse); // R6

endmodule

// File: tb/sim_frame_seq_restart.sv
module sim_frame_seq_restart;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0;
    logic       ref_sync = 1'b0;
    logic [7:0] ctrl_word = 8'h00;
    logic       tid_pulse;
    logic [3:0] tid_count;
    logic       aux_pulse;
    logic [2:0] aux_count;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    frame_seq_restart u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_start(frame_start),
        .ref_sync   (ref_sync),
        .ctrl_word  (ctrl_word),
        .tid_pulse  (tid_pulse),
        .tid_count  (tid_count),
        .aux_pulse  (aux_pulse),
        .aux_count  (aux_count)
    );

    // {ctrl[8], ref, fs, tid_cnt[4], tid_pulse, aux_cnt[4], aux_pulse, req[4]}
    localparam int NV = 20;
    localparam logic [23:0] VEC [NV] = '{
        {8'h00, 1'b0, 1'b1, 4'd0, 1'b0, 4'd1, 1'b0, 4'd4},  // R4 idle ten-frame
        {8'h00, 1'b0, 1'b1, 4'd0, 1'b0, 4'd2, 1'b0, 4'd3},  // R3 aux runs
        {8'h03, 1'b0, 1'b0, 4'd0, 1'b0, 4'd2, 1'b0, 4'd5},  // R5 rising edge only
        {8'h02, 1'b0, 1'b0, 4'd0, 1'b0, 4'd2, 1'b0, 4'd6},  // R6 armed, not yet applied
        {8'h02, 1'b0, 1'b1, 4'd0, 1'b1, 4'd3, 1'b0, 4'd7},  // R7 only ten-frame enabled
        {8'h02, 1'b0, 1'b1, 4'd1, 1'b0, 4'd4, 1'b0, 4'd2},  // R2 advances
        {8'h02, 1'b0, 1'b1, 4'd2, 1'b0, 4'd0, 1'b1, 4'd3},  // R3 aux wrap marker
        {8'h02, 1'b1, 1'b1, 4'd0, 1'b1, 4'd0, 1'b1, 4'd9},  // R9 reference restart
        {8'h00, 1'b0, 1'b1, 4'd1, 1'b0, 4'd1, 1'b0, 4'd9},  // R9 continues
        {8'h05, 1'b0, 1'b0, 4'd1, 1'b0, 4'd1, 1'b0, 4'd5},  // R5 rising edge only
        {8'h04, 1'b0, 1'b1, 4'd2, 1'b0, 4'd2, 1'b0, 4'd12}, // R12 fall with frame_start
        {8'h04, 1'b0, 1'b1, 4'd3, 1'b0, 4'd0, 1'b1, 4'd12}, // R12 applied one frame later
        {8'h04, 1'b0, 1'b1, 4'd4, 1'b0, 4'd1, 1'b0, 4'd8},  // R8 no second restart
        {8'h07, 1'b0, 1'b0, 4'd4, 1'b0, 4'd1, 1'b0, 4'd5},  // R5
        {8'h06, 1'b0, 1'b0, 4'd4, 1'b0, 4'd1, 1'b0, 4'd6},  // R6 armed for both
        {8'h06, 1'b1, 1'b1, 4'd0, 1'b1, 4'd0, 1'b1, 4'd10}, // R10 coincident sources
        {8'h06, 1'b0, 1'b1, 4'd1, 1'b0, 4'd1, 1'b0, 4'd10}, // R10 single restart
        {8'hFE, 1'b0, 1'b0, 4'd1, 1'b0, 4'd1, 1'b0, 4'd11}, // R11 spare bits toggle
        {8'h06, 1'b0, 1'b0, 4'd1, 1'b0, 4'd1, 1'b0, 4'd11}, // R11 spare bits fall
        {8'h06, 1'b0, 1'b1, 4'd2, 1'b0, 4'd2, 1'b0, 4'd11}  // R11 nothing armed
    };

    task automatic check(input string req, input int act, input int exp_v, input string what);
        n_vec++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp_v);
        end
    endtask

    task automatic step(input logic [7:0] c, input logic r, input logic fs);
        ctrl_word   = c;
        ref_sync    = r;
        frame_start = fs;
        @(posedge clk);
        #1;
        frame_start = 1'b0;
        ref_sync    = 1'b0;
    endtask

    task automatic check_all(input string req, input int t, input int tp, input int a, input int ap);
        check(req, int'(tid_count), t, "tid_count");
        check(req, int'(tid_pulse), tp, "tid_pulse");
        check(req, int'(aux_count), a, "aux_count");
        check(req, int'(aux_pulse), ap, "aux_pulse");
    endtask

    task automatic do_reset();
        rst_n     = 1'b0;
        ctrl_word = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset();
        check_all("R1", 0, 0, 0, 0);

        for (int i = 0; i < NV; i++) begin
            logic [23:0] v;
            string tag;
            v = VEC[i];
            step(v[23:16], v[15], v[14]);
            tag = $sformatf("R%0d", v[3:0]);
            check_all(tag, int'(v[13:10]), int'(v[9]), int'(v[8:5]), int'(v[4]));
        end

        // R2 wrap of the ten-frame count (from tid 2, aux 2)
        for (int i = 0; i < 7; i++) step(8'h06, 1'b0, 1'b1);
        check("R2", int'(tid_count), 9, "tid_count at last");
        check("R3", int'(aux_count), 4, "aux_count at last");
        step(8'h06, 1'b0, 1'b1);
        check_all("R2", 0, 1, 0, 1);
        step(8'h06, 1'b0, 1'b0);
        check("R2", int'(tid_pulse), 0, "tid_pulse one clock");

        // R1 / R4 / R5: fresh reset, trigger held high, counter must stay idle
        do_reset();
        check_all("R1", 0, 0, 0, 0);
        for (int i = 0; i < 12; i++) begin
            step(8'h03, 1'b0, 1'b1);
            check("R4", int'(tid_count), 0, "idle count");
            check("R5", int'(tid_pulse), 0, "idle pulse");
        end
        check("R3", int'(aux_count), 2, "aux after 12 frames");

        // R6: release trigger, idle cycles, then boundary starts the counter
        step(8'h02, 1'b0, 1'b0);
        step(8'h02, 1'b0, 1'b0);
        check("R6", int'(tid_pulse), 0, "before boundary");
        step(8'h02, 1'b0, 1'b1);
        check("R6", int'(tid_pulse), 1, "started pulse");
        check("R6", int'(tid_count), 0, "started count");
        step(8'h02, 1'b0, 1'b1);
        check("R8", int'(tid_count), 1, "counts on");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule